// File: doc/BRIEF.md
# Flow-Through Zero-Turnaround Synchronous SRAM

This block is a single-port synchronous memory with a bus that never needs an idle cycle. Reads and writes may follow each other in any order on consecutive clocks. A read is flow-through: the address is registered on a rising edge, and the word appears combinationally on the output during the clock period that follows. A write is late: the address and the per-byte write enables are taken on the edge that starts the cycle, and the data word is taken on the next edge. Because of this one-cycle offset, the data bus can carry useful data on every clock.

Each cycle is opened by an edge with the load/advance select low. That edge fixes the cycle type (read, write or deselect), the base address and the burst order. Edges with the select high continue the open cycle. On those edges a 2-bit counter steps through four beats and then wraps. The burst order is linear or interleaved, chosen at load time. The bidirectional data bus is modelled as `wdata`, `rdata` and `rvalid`, where `rvalid` low stands for high impedance. Incoming write data is held for one edge in a pending stage. A read that hits a pending word receives the new bytes through a bypass. The edge-facing pins are plain memory pins with no handshake; when the clock enable is inactive, the whole block holds its state.

Top module: `zbt_ft_sram`

## Requirements
- R1: After reset is released, `rvalid` is low and `rdata` is zero until a read cycle is loaded.
- R2: An edge with `clk_en_n`=0, `ld_adv_n`=0, `sel_n`=0 and `rd_wr_n`=1 loads a read. During the following clock period, `rdata` shows the word at `addr` and `rvalid` is high, provided `out_en_n` is low.
- R3: An edge with `ld_adv_n`=0, `sel_n`=0 and `rd_wr_n`=0 loads a write and samples `byte_we_n` with it. `wdata` is taken on the next enabled edge. Only the bytes whose enable bit is 0 change: bit k controls bits [8k+7:8k]. `rvalid` stays low during a write cycle.
- R4: A read loaded on the edge that takes the data of the previous write, to the same address, returns the new bytes for the enabled lanes and the old bytes for the other lanes.
- R5: Reads and writes to different addresses may alternate on every clock with no idle cycle, and every read returns the most recently written data.
- R6: With `burst_ilv`=0 at load time, edges with `ld_adv_n`=1 step the two low address bits as base+1, base+2, base+3 (mod 4). The upper bits keep the base.
- R7: With `burst_ilv`=1 at load time, the low two address bits of the beats are base XOR 1, XOR 2, XOR 3.
- R8: A load with `sel_n`=1 opens a deselect cycle. `rvalid` stays low for it and for the advance edges that follow it.
- R9: While `out_en_n` is 1, `rvalid` is low and `rdata` is zero. When `out_en_n` returns to 0, the read word reappears in the same cycle.
- R10: An edge with `clk_en_n`=1 changes no state: the output, the burst position and a pending write all hold, whatever the other inputs are.
- R11: On advance edges, `rd_wr_n`, `sel_n`, `addr` and `burst_ilv` are ignored. The cycle type stays as it was loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en_n | input | 1 | Clock enable, active low; high holds all state |
| sel_n | input | 1 | Chip select, active low, sampled at load |
| rd_wr_n | input | 1 | 1 = read, 0 = write, sampled at load |
| ld_adv_n | input | 1 | 0 = load a new cycle, 1 = advance the burst |
| burst_ilv | input | 1 | Burst order at load: 0 linear, 1 interleaved |
| addr | input | AW | Word address, sampled at load |
| byte_we_n | input | NB | Per-byte write enables, active low, sampled every edge |
| wdata | input | NB*BW | Write data, one edge after its address |
| out_en_n | input | 1 | Output enable, active low, asynchronous |
| rdata | output | NB*BW | Read data, zero when not driven |
| rvalid | output | 1 | Data bus driven; low models high impedance |

## Verification
Two functions can fall in the same cycle: the commit of a late write whose data has just arrived, and a flow-through read of that same word. The bench provokes this by loading a read to the address of a partial-byte write on the edge that carries the write data. It also does this with a clock-enable stall in between. The returned word is compared, byte by byte, against a reference array that the bench updates when it drives the write data. The same reference also judges continuous read/write interleaving and both burst orders.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
  typedef enum logic {
    OP_RD = 1'b0,
    OP_WR = 1'b1
  } op_e;

  // low two address bits of a burst beat
  function automatic logic [1:0] burst_low(input logic [1:0] base,
                                           input logic [1:0] beat,
                                           input logic       ilv);
    return ilv ? (base ^ beat) : (base + beat);
  endfunction
endpackage

// File: rtl/zbt_ctrl.sv
module zbt_ctrl
  import zbt_pkg::*;
#(
  parameter int AW = 8,
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clk_en_n,
  input  logic          sel_n,
  input  logic          rd_wr_n,
  input  logic          ld_adv_n,
  input  logic          burst_ilv,
  input  logic [AW-1:0] addr,
  input  logic [NB-1:0] byte_we_n,
  output logic          act,
  output op_e           op,
  output logic          ilv,
  output logic [AW-1:0] cur_addr,
  output logic [NB-1:0] cur_we_n
);
  logic [AW-1:0] base_q;
  logic [1:0]    beat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act      <= 1'b0;
      op       <= OP_RD;
      ilv      <= 1'b0;
      base_q   <= '0;
      beat_q   <= 2'd0;
      cur_we_n <= '1;
    end else if (!clk_en_n) begin
      cur_we_n <= byte_we_n;
      if (!ld_adv_n) begin
        act    <= !sel_n;
        op     <= rd_wr_n ? OP_RD : OP_WR;
        ilv    <= burst_ilv;
        base_q <= addr;
        beat_q <= 2'd0;
      end else begin
        beat_q <= beat_q + 2'd1;
      end
    end
  end

  assign cur_addr = {base_q[AW-1:2], burst_low(base_q[1:0], beat_q, ilv)};
endmodule

// File: rtl/zbt_wr_stage.sv
module zbt_wr_stage #(
  parameter int AW = 8,
  parameter int NB = 4,
  parameter int BW = 8,
  localparam int DW = NB * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clk_en_n,
  input  logic          cap,
  input  logic [AW-1:0] cap_addr,
  input  logic [NB-1:0] cap_we_n,
  input  logic [DW-1:0] wdata,
  output logic          pw_vld,
  output logic [AW-1:0] pw_addr,
  output logic [NB-1:0] pw_we_n,
  output logic [DW-1:0] pw_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pw_vld  <= 1'b0;
      pw_addr <= '0;
      pw_we_n <= '1;
      pw_data <= '0;
    end else if (!clk_en_n) begin
      pw_vld <= cap;
      if (cap) begin
        pw_addr <= cap_addr;
        pw_we_n <= cap_we_n;
        pw_data <= wdata;
      end
    end
  end
endmodule

// File: rtl/zbt_array.sv
module zbt_array #(
  parameter int AW = 8,
  parameter int NB = 4,
  parameter int BW = 8,
  localparam int DW = NB * BW,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          clk_en_n,
  input  logic          pw_vld,
  input  logic [AW-1:0] pw_addr,
  input  logic [NB-1:0] pw_we_n,
  input  logic [DW-1:0] pw_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [BW-1:0] lane [DEPTH];
    logic          hit;

    always_ff @(posedge clk) begin
      if (!clk_en_n && pw_vld && !pw_we_n[g])
        lane[pw_addr] <= pw_data[g*BW +: BW];
    end

    assign hit = pw_vld && !pw_we_n[g] && (pw_addr == rd_addr);
    assign rd_data[g*BW +: BW] = hit ? pw_data[g*BW +: BW] : lane[rd_addr];
  end
endmodule

// File: rtl/zbt_ft_sram.sv
module zbt_ft_sram
  import zbt_pkg::*;
#(
  parameter int AW = 8,
  parameter int NB = 4,
  parameter int BW = 8,
  localparam int DW = NB * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clk_en_n,
  input  logic          sel_n,
  input  logic          rd_wr_n,
  input  logic          ld_adv_n,
  input  logic          burst_ilv,
  input  logic [AW-1:0] addr,
  input  logic [NB-1:0] byte_we_n,
  input  logic [DW-1:0] wdata,
  input  logic          out_en_n,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);
  logic          cur_act;
  op_e           cur_op;
  logic          cur_ilv;
  logic [AW-1:0] cur_addr;
  logic [NB-1:0] cur_we_n;
  logic          pw_vld;
  logic [AW-1:0] pw_addr;
  logic [NB-1:0] pw_we_n;
  logic [DW-1:0] pw_data;
  logic [DW-1:0] arr_data;

  zbt_ctrl #(.AW(AW), .NB(NB)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .sel_n(sel_n),
    .rd_wr_n(rd_wr_n), .ld_adv_n(ld_adv_n), .burst_ilv(burst_ilv),
    .addr(addr), .byte_we_n(byte_we_n), .act(cur_act), .op(cur_op),
    .ilv(cur_ilv), .cur_addr(cur_addr), .cur_we_n(cur_we_n)
  );

  zbt_wr_stage #(.AW(AW), .NB(NB), .BW(BW)) u_wr (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n),
    .cap(cur_act && (cur_op == OP_WR)), .cap_addr(cur_addr),
    .cap_we_n(cur_we_n), .wdata(wdata), .pw_vld(pw_vld),
    .pw_addr(pw_addr), .pw_we_n(pw_we_n), .pw_data(pw_data)
  );

  zbt_array #(.AW(AW), .NB(NB), .BW(BW)) u_arr (
    .clk(clk), .clk_en_n(clk_en_n), .pw_vld(pw_vld), .pw_addr(pw_addr),
    .pw_we_n(pw_we_n), .pw_data(pw_data), .rd_addr(cur_addr),
    .rd_data(arr_data)
  );

  assign rvalid = cur_act && (cur_op == OP_RD) && !out_en_n;
  assign rdata  = rvalid ? arr_data : '0;
endmodule

// File: rtl/zbt_sram_chk.sv
module zbt_sram_chk #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clk_en_n,
  input logic          sel_n,
  input logic          rd_wr_n,
  input logic          ld_adv_n,
  input logic          out_en_n,
  input logic [DW-1:0] rdata,
  input logic          rvalid,
  input logic          cur_act,
  input logic          cur_ilv,
  input logic [AW-1:0] cur_addr
);
  assert_read_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !ld_adv_n && !sel_n && rd_wr_n) |=> (rvalid || out_en_n));

  assert_write_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !ld_adv_n && !sel_n && !rd_wr_n) |=> !rvalid);

  assert_linear_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && ld_adv_n && !cur_ilv && cur_act) |=>
      (cur_addr[1:0] == $past(cur_addr[1:0]) + 2'd1) &&
      (cur_addr[AW-1:2] == $past(cur_addr[AW-1:2])));

  assert_deselect_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !ld_adv_n && sel_n) |=> !rvalid);

  assert_oe_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> (!rvalid && rdata == '0));

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> (!$stable(out_en_n) || ($stable(rvalid) && $stable(rdata))));
endmodule

bind zbt_ft_sram zbt_sram_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .sel_n(sel_n),
  .rd_wr_n(rd_wr_n), .ld_adv_n(ld_adv_n), .out_en_n(out_en_n),
  .rdata(rdata), .rvalid(rvalid), .cur_act(cur_act), .cur_ilv(cur_ilv),
  .cur_addr(cur_addr)
);

// File: tb/sim_zbt_ft_sram.sv
`timescale 1ns/1ps
module sim_zbt_ft_sram;
  localparam int AW = 8;
  localparam int NB = 4;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clk_en_n = 1'b0;
  logic          sel_n = 1'b1;
  logic          rd_wr_n = 1'b1;
  logic          ld_adv_n = 1'b0;
  logic          burst_ilv = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [NB-1:0] byte_we_n = '1;
  logic [DW-1:0] wdata = '0;
  logic          out_en_n = 1'b0;
  logic [DW-1:0] rdata;
  logic          rvalid;

  int n_chk = 0;
  int n_fail = 0;

  // bench reference model
  logic [DW-1:0] ref_mem [1<<AW];
  logic          m_act = 1'b0, m_wr = 1'b0, m_ilv = 1'b0;
  logic [AW-1:0] m_base = '0, m_addr = '0, m_waddr = '0;
  logic [1:0]    m_cnt = 2'd0;
  logic          m_wact = 1'b0;
  logic [NB-1:0] m_wbe = '1;

  always #10 clk = ~clk;

  zbt_ft_sram #(.AW(AW), .NB(NB), .BW(8)) u0 (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .sel_n(sel_n),
    .rd_wr_n(rd_wr_n), .ld_adv_n(ld_adv_n), .burst_ilv(burst_ilv),
    .addr(addr), .byte_we_n(byte_we_n), .wdata(wdata),
    .out_en_n(out_en_n), .rdata(rdata), .rvalid(rvalid)
  );

  function automatic logic [DW-1:0] pat(input int i);
    return (32'h0101_0101 * i) ^ 32'h5A3C_96E1;
  endfunction

  task automatic chk(input string tag);
    logic          ev;
    logic [DW-1:0] ed;
    ev = m_act && !m_wr && !out_en_n;
    ed = ev ? ref_mem[m_addr] : '0;
    n_chk++;
    if (rvalid !== ev || rdata !== ed) begin
      n_fail++;
      $display("FAIL %s: rvalid=%b rdata=%h expected rvalid=%b rdata=%h",
               tag, rvalid, rdata, ev, ed);
    end
  endtask

  // drive one enabled cycle, advance the model, check after the edge
  task automatic drv(input logic adv, input logic sn, input logic rd,
                     input logic md, input logic [AW-1:0] a,
                     input logic [NB-1:0] be, input logic [DW-1:0] d,
                     input string tag);
    clk_en_n = 1'b0; ld_adv_n = adv; sel_n = sn; rd_wr_n = rd;
    burst_ilv = md; addr = a; byte_we_n = be; wdata = d;
    if (m_wact)
      for (int b = 0; b < NB; b++)
        if (!m_wbe[b]) ref_mem[m_waddr][b*8 +: 8] = d[b*8 +: 8];
    if (!adv) begin
      m_act = !sn; m_wr = !rd; m_base = a; m_cnt = 2'd0; m_ilv = md;
    end else begin
      m_cnt = m_cnt + 2'd1;
    end
    m_addr  = {m_base[AW-1:2], m_ilv ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt)};
    m_wact  = m_act && m_wr;
    m_waddr = m_addr;
    m_wbe   = be;
    @(posedge clk); @(negedge clk);
    chk(tag);
  endtask

  task automatic stall(input string tag);
    clk_en_n = 1'b1; rd_wr_n = ~rd_wr_n; ld_adv_n = ~ld_adv_n;
    addr = ~addr; wdata = 32'hDEAD_BEEF; sel_n = ~sel_n; byte_we_n = ~byte_we_n;
    @(posedge clk); @(negedge clk);
    chk(tag);
  endtask

  task automatic t_reset();
    chk("R1 reset state");
  endtask

  task automatic t_single();
    for (int i = 0; i < 8; i++)
      drv(0, 0, 0, 0, AW'(i), 4'h0, pat(i + 99), "R3 write load");
    drv(0, 0, 1, 0, 8'd0, 4'hF, pat(7), "R2 read after write data");
    for (int i = 1; i < 8; i++)
      drv(0, 0, 1, 0, AW'(i), 4'hF, 32'h0, "R2 single read");
  endtask

  task automatic t_bytes();
    drv(0, 0, 0, 0, 8'd16, 4'h0, 32'h0, "R3 full write");
    drv(0, 0, 0, 0, 8'd16, 4'b1010, 32'h1122_3344, "R3 partial write");
    drv(0, 0, 1, 0, 8'd16, 4'hF, 32'hAABB_CCDD, "R4 bypass merge");
    drv(0, 0, 1, 0, 8'd16, 4'hF, 32'h0, "R3 committed bytes");
    drv(0, 0, 0, 0, 8'd17, 4'h0, 32'h0, "R3 write");
    drv(0, 0, 0, 0, 8'd17, 4'b0110, 32'h0F0F_0F0F, "R3 partial write");
    drv(0, 0, 1, 0, 8'd17, 4'hF, 32'h9988_7766, "R4 bypass merge lanes 0,3");
  endtask

  task automatic t_mix();
    for (int i = 0; i < 6; i++) begin
      drv(0, 0, 0, 0, AW'(40 + i), 4'h0, pat(i + 3), "R5 write in mix");
      drv(0, 0, 1, 0, AW'(40 + (i % 2)), 4'hF, pat(i + 50), "R5 read in mix");
    end
    drv(0, 0, 1, 0, 8'd45, 4'hF, 32'h0, "R5 final read");
  endtask

  task automatic t_bursts();
    drv(0, 0, 0, 0, 8'd34, 4'h0, 32'h0, "R6 write burst load");
    for (int i = 0; i < 3; i++)
      drv(1, 0, 0, 0, 8'd0, 4'h0, pat(i + 200), "R6 write burst beat");
    drv(0, 0, 0, 1, 8'd37, 4'h0, pat(203), "R7 write burst load");
    for (int i = 0; i < 3; i++)
      drv(1, 0, 0, 1, 8'd0, 4'h0, pat(i + 300), "R7 write burst beat");
    drv(0, 0, 1, 0, 8'd33, 4'hF, pat(303), "R6 linear read load");
    for (int i = 0; i < 4; i++)
      drv(1, 0, 1, 1, 8'hFF, 4'hF, 32'h0, "R6 linear beat and wrap");
    drv(0, 0, 1, 1, 8'd39, 4'hF, 32'h0, "R7 interleaved read load");
    for (int i = 0; i < 3; i++)
      drv(1, 0, 1, 0, 8'h00, 4'hF, 32'h0, "R7 interleaved beat");
  endtask

  task automatic t_desel();
    drv(0, 1, 1, 0, 8'd0, 4'hF, 32'h0, "R8 deselect load");
    drv(1, 0, 1, 0, 8'd0, 4'hF, 32'h0, "R8 deselect advance");
    drv(1, 0, 0, 0, 8'd0, 4'h0, 32'h0, "R8 deselect advance");
    drv(0, 0, 1, 0, 8'd1, 4'hF, 32'h0, "R8 recovery read");
  endtask

  task automatic t_oe();
    out_en_n = 1'b1;
    drv(0, 0, 1, 0, 8'd2, 4'hF, 32'h0, "R9 output disabled");
    out_en_n = 1'b0; #1;
    chk("R9 output re-enabled");
  endtask

  task automatic t_stall();
    drv(0, 0, 1, 0, 8'd40, 4'hF, 32'h0, "R10 read burst load");
    stall("R10 stalled read holds");
    stall("R10 stalled read holds");
    drv(1, 0, 1, 0, 8'd0, 4'hF, 32'h0, "R10 burst resumes");
    drv(0, 0, 0, 0, 8'd50, 4'h0, 32'h0, "R10 write load");
    stall("R10 stall before data");
    drv(0, 0, 1, 0, 8'd50, 4'hF, 32'hCAFE_F00D, "R10 write data after stall");
    stall("R10 stall with pending write");
    drv(0, 0, 1, 0, 8'd50, 4'hF, 32'h0, "R10 pending write kept");
  endtask

  task automatic t_type();
    drv(0, 0, 1, 0, 8'd4, 4'hF, 32'h0, "R11 read burst load");
    drv(1, 1, 0, 1, 8'd99, 4'h0, 32'h1234_5678, "R11 type fixed as read");
    drv(1, 1, 0, 1, 8'd99, 4'h0, 32'h1234_5678, "R11 type fixed as read");
    drv(0, 0, 0, 0, 8'd60, 4'h0, 32'h0, "R11 write burst load");
    drv(1, 1, 1, 1, 8'd7, 4'h0, pat(600), "R11 type fixed as write");
    drv(0, 0, 1, 0, 8'd60, 4'hF, pat(601), "R11 read back beat 0");
    drv(1, 0, 1, 0, 8'd0, 4'hF, 32'h0, "R11 read back beat 1");
    drv(1, 0, 1, 0, 8'd0, 4'hF, 32'h0, "R11 read back beat 2");
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_bytes();
    t_mix();
    t_bursts();
    t_desel();
    t_oe();
    t_stall();
    t_type();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule